// File: doc/BRIEF.md
# Adaptive-Depth Stride Prefetcher

This block watches the miss stream of a data cache and learns, per load instruction, the constant distance between that load's successive miss addresses. Each miss arrives as a pair: the program counter of the load and the address that missed. A small fully associative table keyed by program counter holds what has been learned. Once a load has shown the same stride often enough, every further miss by that load starts a burst of prefetch requests. The requests run ahead of the miss by one stride, two strides, and so on. They are handed to an external prefetch queue with a valid/ready handshake.

The length of the burst, called the degree, is kept separately for each table entry and starts at one. The queue performs the address lookup. When a demand miss finds its own address still waiting in the queue, it reports this on `miss_queued`. That tells the block the load is catching up with its prefetches, so the entry's degree grows by one, up to a ceiling. A later miss always replaces a burst that has not finished.

Top module: `stride_pf`

## Requirements
- R1: After reset `pf_valid` is low and stays low until a trained entry sees a miss.
- R2: The first miss of an unknown PC allocates an entry and records its address. The second miss by that PC records the stride as the difference of the two addresses. Neither miss issues a prefetch.
- R3: Each later miss whose difference from the stored address equals the stored stride raises a 2-bit saturating confidence. A burst starts only when the updated confidence exceeds 1, which first happens on the fourth miss of a steady stream.
- R4: The first address of a burst is the miss address plus the stride, presented on `pf_addr` in the cycle after the miss. A fresh entry has degree 1.
- R5: A stride mismatch clears confidence to 0 and stores the new difference as the stride. Every miss by a PC stores that miss address as the entry's last address.
- R6: A miss with `miss_queued` high on a known PC raises that entry's degree by one, saturating at 8. The raised degree applies to the burst started by that same miss.
- R7: A burst of degree d presents miss + k*stride for k = 1..d in order, advancing only on cycles where `pf_valid` and `pf_ready` are both high. While `pf_ready` is low, `pf_addr` holds.
- R8: A new miss ends any unfinished burst. If that miss does not itself start a burst, `pf_valid` is low in the following cycle.
- R9: The table holds 8 entries. When it is full, a new PC replaces the entry that was allocated longest ago. Entries that are not replaced keep their training.
- R10: Strides are computed modulo 2^ADDR_W, so descending streams with negative strides are learned and prefetched the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A demand miss is presented this cycle |
| miss_pc | input | PC_W | Program counter of the missing load |
| miss_addr | input | ADDR_W | Address that missed |
| miss_queued | input | 1 | The queue already holds miss_addr as a pending prefetch |
| pf_ready | input | 1 | Prefetch queue can accept an address |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_addr | output | ADDR_W | Prefetch address |

## Verification
The bench uses the default build: 8 entries, 32-bit PCs and addresses, a maximum degree of 8 and a confidence threshold of 1. With these values one stream can walk its degree from 1 to the ceiling in seven queue hits and then show that the degree stays there. Eight other PCs fill the table and force the oldest entry out. A burst can also be long enough to be stalled by a low `pf_ready` and cut short by a new miss.

// File: rtl/stride_pf.sv
module stride_pf #(
  parameter int ENTRIES  = 8,
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int MAX_DEG  = 8,
  parameter int CONF_THR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [PC_W-1:0]   miss_pc,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              miss_queued,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int DEG_W = $clog2(MAX_DEG + 1);
  localparam logic [DEG_W-1:0] DEG_MAX = DEG_W'(MAX_DEG);
  localparam logic [1:0] THR = 2'(CONF_THR);

  logic              t_vld [ENTRIES];
  logic              t_has [ENTRIES];
  logic [PC_W-1:0]   t_pc  [ENTRIES];
  logic [ADDR_W-1:0] t_last[ENTRIES];
  logic [ADDR_W-1:0] t_str [ENTRIES];
  logic [1:0]        t_conf[ENTRIES];
  logic [DEG_W-1:0]  t_deg [ENTRIES];
  logic [IDX_W-1:0]  alloc_ptr;

  logic              hit;
  logic [IDX_W-1:0]  hidx;
  logic [ADDR_W-1:0] diff;
  logic              same;
  logic [1:0]        conf_n;
  logic [DEG_W-1:0]  deg_n;
  logic              start;

  logic              seq_act;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] seq_stride;
  logic [DEG_W-1:0]  seq_k;
  logic [DEG_W-1:0]  seq_d;

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (t_vld[i] && t_pc[i] == miss_pc) begin
        hit  = 1'b1;
        hidx = IDX_W'(i);
      end
  end

  assign diff   = miss_addr - t_last[hidx];
  assign same   = t_has[hidx] && (diff == t_str[hidx]);
  assign conf_n = !same ? 2'd0 : (t_conf[hidx] == 2'd3) ? 2'd3 : t_conf[hidx] + 2'd1;
  assign deg_n  = (miss_queued && t_deg[hidx] != DEG_MAX) ? t_deg[hidx] + 1'b1 : t_deg[hidx];
  assign start  = miss_valid && hit && same && (conf_n > THR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_ptr <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        t_vld[i]  <= 1'b0;
        t_has[i]  <= 1'b0;
        t_pc[i]   <= '0;
        t_last[i] <= '0;
        t_str[i]  <= '0;
        t_conf[i] <= '0;
        t_deg[i]  <= DEG_W'(1);
      end
    end else if (miss_valid) begin
      if (hit) begin
        t_last[hidx] <= miss_addr;
        t_has[hidx]  <= 1'b1;
        t_conf[hidx] <= conf_n;
        t_deg[hidx]  <= deg_n;
        if (!same) t_str[hidx] <= diff;
      end else begin
        t_vld[alloc_ptr]  <= 1'b1;
        t_has[alloc_ptr]  <= 1'b0;
        t_pc[alloc_ptr]   <= miss_pc;
        t_last[alloc_ptr] <= miss_addr;
        t_str[alloc_ptr]  <= '0;
        t_conf[alloc_ptr] <= '0;
        t_deg[alloc_ptr]  <= DEG_W'(1);
        alloc_ptr <= (alloc_ptr == IDX_W'(ENTRIES - 1)) ? '0 : alloc_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_act    <= 1'b0;
      seq_addr   <= '0;
      seq_stride <= '0;
      seq_k      <= '0;
      seq_d      <= '0;
    end else if (miss_valid) begin
      seq_act    <= start;
      seq_addr   <= miss_addr + diff;
      seq_stride <= diff;
      seq_k      <= DEG_W'(1);
      seq_d      <= deg_n;
    end else if (seq_act && pf_ready) begin
      if (seq_k >= seq_d) seq_act <= 1'b0;
      else begin
        seq_addr <= seq_addr + seq_stride;
        seq_k    <= seq_k + 1'b1;
      end
    end
  end

  assign pf_valid = seq_act;
  assign pf_addr  = seq_addr;
endmodule

module stride_pf_chk #(
  parameter int ADDR_W  = 32,
  parameter int DEG_W   = 4,
  parameter int MAX_DEG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr,
  input logic [ADDR_W-1:0] seq_stride,
  input logic [DEG_W-1:0]  seq_k,
  input logic [DEG_W-1:0]  seq_d
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready && !miss_valid |=> pf_valid && $stable(pf_addr));
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && !miss_valid && seq_k < seq_d |=>
      pf_valid && pf_addr == $past(pf_addr) + $past(seq_stride));
  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(miss_valid));
  p_deg_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> seq_d >= DEG_W'(1) && seq_d <= DEG_W'(MAX_DEG) && seq_k <= seq_d);
  p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && !miss_valid && seq_k == seq_d |=> !pf_valid);
endmodule

bind stride_pf stride_pf_chk #(.ADDR_W(ADDR_W), .DEG_W(DEG_W), .MAX_DEG(MAX_DEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .pf_valid(pf_valid),
  .pf_ready(pf_ready), .pf_addr(pf_addr), .seq_stride(seq_stride),
  .seq_k(seq_k), .seq_d(seq_d));

// File: tb/tb_stride_pf.sv
module tb_stride_pf;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        miss_valid = 0;
  logic [31:0] miss_pc = 0;
  logic [31:0] miss_addr = 0;
  logic        miss_queued = 0;
  logic        pf_ready = 1;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] q_mem [256];
  int q_cnt = 0;

  always #10 clk = ~clk;

  stride_pf dut (.*);

  always @(posedge clk)
    if (rst_n && pf_valid && pf_ready && q_cnt < 256) begin
      q_mem[q_cnt] <= pf_addr;
      q_cnt <= q_cnt + 1;
    end

  function automatic bit in_queue(input logic [31:0] a);
    for (int i = 0; i < q_cnt; i++) if (q_mem[i] == a) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_miss(input logic [31:0] pc, input logic [31:0] a);
    @(negedge clk);
    miss_valid = 1; miss_pc = pc; miss_addr = a; miss_queued = in_queue(a);
    @(posedge clk);
    @(negedge clk);
    miss_valid = 0; miss_queued = 0;
  endtask

  task automatic expect_idle(input string tag);
    chk(!pf_valid, tag, {31'd0, pf_valid}, 32'd0);
  endtask

  task automatic expect_seq(input logic [31:0] base, input logic [31:0] s, input int d, input string tag);
    for (int k = 1; k <= d; k++) begin
      chk(pf_valid && pf_addr == base + k * s, tag, pf_addr, base + k * s);
      @(negedge clk);
    end
    expect_idle(tag);
  endtask

  function automatic logic [31:0] a_n(input int n);
    return 32'h1000 + n * 32'h40;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    expect_idle("R1 reset");
    rst_n = 1;
    @(negedge clk);
    expect_idle("R1 after reset");
  endtask

  task automatic t_train();
    do_miss(32'h100, a_n(0)); expect_idle("R2 first miss");
    do_miss(32'h100, a_n(1)); expect_idle("R2 second miss");
    do_miss(32'h100, a_n(2)); expect_idle("R3 conf 1 below threshold");
    do_miss(32'h100, a_n(3)); expect_seq(a_n(3), 32'h40, 1, "R4 first burst degree 1");
  endtask

  task automatic t_degree();
    for (int n = 4; n <= 10; n++) begin
      do_miss(32'h100, a_n(n));
      expect_seq(a_n(n), 32'h40, n - 2, "R6 degree rise");
    end
    do_miss(32'h100, a_n(11));
    expect_seq(a_n(11), 32'h40, 8, "R6 degree saturates at 8");
  endtask

  task automatic t_abort();
    do_miss(32'h100, a_n(12));
    chk(pf_valid && pf_addr == a_n(13), "R8 burst start", pf_addr, a_n(13));
    @(negedge clk);
    chk(pf_valid && pf_addr == a_n(14), "R8 burst second", pf_addr, a_n(14));
    do_miss(32'h200, 32'h7000);
    expect_idle("R8 new miss ends burst");
  endtask

  task automatic t_stall();
    pf_ready = 0;
    do_miss(32'h100, a_n(13));
    for (int i = 0; i < 3; i++) begin
      chk(pf_valid && pf_addr == a_n(14), "R7 hold while not ready", pf_addr, a_n(14));
      @(negedge clk);
    end
    pf_ready = 1;
    expect_seq(a_n(13), 32'h40, 8, "R7 drain after stall");
  endtask

  task automatic t_mismatch();
    do_miss(32'h300, 32'h2000);
    do_miss(32'h300, 32'h2100);
    do_miss(32'h300, 32'h2200); expect_idle("R5 training");
    do_miss(32'h300, 32'h2250); expect_idle("R5 mismatch clears conf");
    do_miss(32'h300, 32'h22A0); expect_idle("R5 new stride conf 1");
    do_miss(32'h300, 32'h22F0); expect_seq(32'h22F0, 32'h50, 1, "R5 new stride used");
  endtask

  task automatic t_negative();
    do_miss(32'h400, 32'h9000);
    do_miss(32'h400, 32'h8FC0);
    do_miss(32'h400, 32'h8F80);
    do_miss(32'h400, 32'h8F40);
    expect_seq(32'h8F40, 32'hFFFF_FFC0, 1, "R10 negative stride");
  endtask

  task automatic t_replace();
    for (int i = 0; i < 4; i++) do_miss(32'h500 + i * 32'h10, 32'hA000 + i * 32'h1000);
    do_miss(32'h600, 32'hF000);
    expect_idle("R9 ninth pc allocates");
    do_miss(32'h100, 32'h6000); expect_idle("R9 evicted pc retrains");
    do_miss(32'h100, 32'h6040); expect_idle("R9 evicted pc retrains");
    do_miss(32'h100, 32'h6080); expect_idle("R9 evicted pc retrains");
    do_miss(32'h100, 32'h60C0);
    expect_seq(32'h60C0, 32'h40, 1, "R9 evicted pc restarts at degree 1");
    do_miss(32'h300, 32'h2340);
    expect_seq(32'h2340, 32'h50, 2, "R9 retained entry keeps training");
  endtask

  initial begin
    t_reset();
    t_train();
    t_degree();
    t_abort();
    t_stall();
    t_mismatch();
    t_negative();
    t_replace();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule